// File: doc/BRIEF.md
# Auxiliary Register Address Unit

This block holds a bank of eight 16-bit pointer registers that a signal-processing core uses for indirect data addressing and for loop counting. A 3-bit pointer names the current register, and the value of that register is always presented as the data address. The instruction decoder sits outside the block. It supplies one-cycle operation strobes and immediate fields, and the unit updates its state on the following clock edge.

The supported operations are: loading any register, adding or subtracting a short unsigned constant on the current register, and comparing the current register with register 0 under a selectable unsigned condition. The compare result goes to a test flag. An indirect-mode modify can step the current register up or down by one, and it can also give the pointer a new value after the access. The unit also evaluates the loop branch: the branch is taken when the current register is non-zero, and the decision carries its cycle cost. This decision can be made in the same cycle as a pointer-register decrement. The decision then uses the value from before the decrement.

Top module: `aux_addr_unit`

## Requirements
- R1: After reset, every register is 0, the pointer is 0, the test flag is 0, and loop_valid, loop_taken and loop_cost are 0.
- R2: data_addr always equals the register named by the pointer, as held after the most recent clock edge.
- R3: With ld_en, the register named by ld_sel (which need not be the current one) takes ld_val at the next edge.
- R4: With add_en, the current register gains the zero-extended 8-bit imm, wrapping modulo 2^16.
- R5: With sub_en, the current register loses the zero-extended 8-bit imm, wrapping modulo 2^16.
- R6: With cmp_en, test_flag takes the unsigned comparison of the current register against register 0. cmp_cond encodes 00 equal, 01 less than, 10 greater than, 11 not equal. Without cmp_en the flag holds its value.
- R7: An indirect modify (mod_en with mod_ind=1) applies mod_step to the current register: 00 no change, 01 plus one, 10 minus one, 11 no change.
- R8: An indirect modify with mod_ptr_ld sets the pointer to mod_ptr after the access. Any step in the same cycle applies to the register the old pointer named.
- R9: A modify with mod_ind=0 (direct mode) changes neither the registers nor the pointer.
- R10: With loop_en, in the next cycle loop_valid=1 and loop_taken=1 if the current register was non-zero. loop_cost is then 4 when the branch is taken and 2 when it is not. In cycles without a loop request, all three outputs are 0.
- R11: When a loop request and an indirect modify arrive together, the loop decision uses the register value from before the modify.
- R12: When more than one register write is requested in the same cycle, only the highest-priority one is performed. The priority order is load, then add, then subtract, then modify step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Register to load |
| ld_val | input | 16 | Load value |
| add_en | input | 1 | Add-constant strobe |
| sub_en | input | 1 | Subtract-constant strobe |
| imm | input | 8 | Unsigned constant |
| cmp_en | input | 1 | Compare strobe |
| cmp_cond | input | 2 | Compare condition |
| mod_en | input | 1 | Modify strobe |
| mod_ind | input | 1 | 1 for indirect mode, 0 for direct |
| mod_step | input | 2 | Step code for the current register |
| mod_ptr_ld | input | 1 | Load a new pointer after the access |
| mod_ptr | input | 3 | New pointer value |
| loop_en | input | 1 | Loop-branch evaluation strobe |
| data_addr | output | 16 | Current register value |
| cur_ptr | output | 3 | Current pointer |
| test_flag | output | 1 | Compare result |
| loop_valid | output | 1 | Loop decision present |
| loop_taken | output | 1 | Loop branch taken |
| loop_cost | output | 3 | Cycle cost of the loop decision |

## Verification
The add and subtract paths are tested with values that do not wrap and with values that cross the 16-bit boundary in each direction, so that a missing wrap or a sign-extended immediate shows up. The compare is run with the current register below, equal to and above register 0, which separates all four condition codes from one another. Loop requests are issued against a zero register and against a register that counts down to zero during a combined decrement. This shows whether the decision uses the value before or after the modify. Operations are also issued in pairs in the same cycle to expose the write priority, and direct-mode modifies are issued to check that they change nothing.

// File: rtl/aux_addr_pkg.sv
package aux_addr_pkg;
  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_LT = 2'b01,
    CMP_GT = 2'b10,
    CMP_NE = 2'b11
  } cmp_cond_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10,
    STEP_RSV  = 2'b11
  } step_e;
endpackage

// File: rtl/aux_bank.sv
module aux_bank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] ref_data
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (hit) regs_q[g] <= wr_data;
    end
  end

  assign rd_data  = regs_q[rd_idx];
  assign ref_data = regs_q[0];
endmodule

// File: rtl/aux_compare.sv
module aux_compare
  import aux_addr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] cur_val,
  input  logic [DATA_W-1:0] ref_val,
  input  logic [1:0]        cond,
  output logic              hit
);
  always_comb begin
    case (cmp_cond_e'(cond))
      CMP_EQ:  hit = (cur_val == ref_val);
      CMP_LT:  hit = (cur_val <  ref_val);
      CMP_GT:  hit = (cur_val >  ref_val);
      default: hit = (cur_val != ref_val);
    endcase
  end
endmodule

// File: rtl/aux_update.sv
module aux_update
  import aux_addr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8,
  parameter int PTR_W  = 3
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [DATA_W-1:0] cur_val,
  input  logic              ld_en,
  input  logic [PTR_W-1:0]  ld_sel,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              add_en,
  input  logic              sub_en,
  input  logic [IMM_W-1:0]  imm,
  input  logic              step_act,
  input  logic [1:0]        step,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);
  localparam int PAD_W = DATA_W - IMM_W;
  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = {{PAD_W{1'b0}}, imm};

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = ptr;
    wr_data = cur_val;
    if (ld_en) begin
      wr_en   = 1'b1;
      wr_idx  = ld_sel;
      wr_data = ld_val;
    end else if (add_en) begin
      wr_en   = 1'b1;
      wr_data = cur_val + imm_ext;
    end else if (sub_en) begin
      wr_en   = 1'b1;
      wr_data = cur_val - imm_ext;
    end else if (step_act) begin
      case (step_e'(step))
        STEP_INC: begin
          wr_en   = 1'b1;
          wr_data = cur_val + DATA_W'(1);
        end
        STEP_DEC: begin
          wr_en   = 1'b1;
          wr_data = cur_val - DATA_W'(1);
        end
        default: wr_en = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/aux_addr_unit.sv
module aux_addr_unit #(
  parameter int NUM_REGS      = 8,
  parameter int DATA_W        = 16,
  parameter int IMM_W         = 8,
  parameter int TAKEN_CYC     = 4,
  parameter int NOT_TAKEN_CYC = 2,
  parameter int PTR_W         = $clog2(NUM_REGS),
  parameter int COST_W        = $clog2(TAKEN_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [PTR_W-1:0]  ld_sel,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              add_en,
  input  logic              sub_en,
  input  logic [IMM_W-1:0]  imm,
  input  logic              cmp_en,
  input  logic [1:0]        cmp_cond,
  input  logic              mod_en,
  input  logic              mod_ind,
  input  logic [1:0]        mod_step,
  input  logic              mod_ptr_ld,
  input  logic [PTR_W-1:0]  mod_ptr,
  input  logic              loop_en,
  output logic [DATA_W-1:0] data_addr,
  output logic [PTR_W-1:0]  cur_ptr,
  output logic              test_flag,
  output logic              loop_valid,
  output logic              loop_taken,
  output logic [COST_W-1:0] loop_cost
);
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              flag_q, flag_d;
  logic              lv_q, lv_d, lt_q, lt_d;
  logic [COST_W-1:0] cost_q, cost_d;
  logic [DATA_W-1:0] cur_val, ref_val, wr_data;
  logic [PTR_W-1:0]  wr_idx;
  logic              wr_en, cmp_hit, mod_act;

  assign mod_act = mod_en && mod_ind;

  aux_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PTR_W(PTR_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(ptr_q), .rd_data(cur_val), .ref_data(ref_val)
  );

  aux_update #(.DATA_W(DATA_W), .IMM_W(IMM_W), .PTR_W(PTR_W)) i_update (
    .ptr(ptr_q), .cur_val(cur_val), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_val(ld_val), .add_en(add_en), .sub_en(sub_en), .imm(imm),
    .step_act(mod_act), .step(mod_step),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  aux_compare #(.DATA_W(DATA_W)) i_cmp (
    .cur_val(cur_val), .ref_val(ref_val), .cond(cmp_cond), .hit(cmp_hit)
  );

  always_comb begin
    ptr_d  = ptr_q;
    flag_d = flag_q;
    lv_d   = 1'b0;
    lt_d   = 1'b0;
    cost_d = '0;
    if (mod_act && mod_ptr_ld) ptr_d = mod_ptr;
    if (cmp_en) flag_d = cmp_hit;
    if (loop_en) begin
      lv_d   = 1'b1;
      lt_d   = (cur_val != '0);
      cost_d = lt_d ? COST_W'(TAKEN_CYC) : COST_W'(NOT_TAKEN_CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      flag_q <= 1'b0;
      lv_q   <= 1'b0;
      lt_q   <= 1'b0;
      cost_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      flag_q <= flag_d;
      lv_q   <= lv_d;
      lt_q   <= lt_d;
      cost_q <= cost_d;
    end
  end

  assign data_addr  = cur_val;
  assign cur_ptr    = ptr_q;
  assign test_flag  = flag_q;
  assign loop_valid = lv_q;
  assign loop_taken = lt_q;
  assign loop_cost  = cost_q;
endmodule

// File: rtl/aux_addr_unit_chk.sv
module aux_addr_unit_chk #(
  parameter int DATA_W        = 16,
  parameter int IMM_W         = 8,
  parameter int PTR_W         = 3,
  parameter int COST_W        = 3,
  parameter int TAKEN_CYC     = 4,
  parameter int NOT_TAKEN_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic              add_en,
  input logic              sub_en,
  input logic [IMM_W-1:0]  imm,
  input logic              cmp_en,
  input logic              mod_en,
  input logic              mod_ind,
  input logic              mod_ptr_ld,
  input logic              loop_en,
  input logic [DATA_W-1:0] data_addr,
  input logic [PTR_W-1:0]  cur_ptr,
  input logic              test_flag,
  input logic              loop_valid,
  input logic              loop_taken,
  input logic [COST_W-1:0] loop_cost
);
  logic ptr_move;
  assign ptr_move = mod_en && mod_ind && mod_ptr_ld;

  // R4
  add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !ld_en && !ptr_move) |=>
      data_addr == DATA_W'($past(data_addr) + {{(DATA_W-IMM_W){1'b0}}, $past(imm)}));

  // R5
  sub_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en && !add_en && !ld_en && !ptr_move) |=>
      data_addr == DATA_W'($past(data_addr) - {{(DATA_W-IMM_W){1'b0}}, $past(imm)}));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(test_flag));

  // R9
  direct_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !mod_ind && !ld_en && !add_en && !sub_en) |=>
      ($stable(cur_ptr) && $stable(data_addr)));

  // R10
  loop_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> (loop_valid && (loop_taken == ($past(data_addr) != '0))));

  // R10
  loop_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_valid |-> (loop_cost == (loop_taken ? COST_W'(TAKEN_CYC) : COST_W'(NOT_TAKEN_CYC))));

  // R10
  loop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> (!loop_valid && !loop_taken && loop_cost == '0));
endmodule

bind aux_addr_unit aux_addr_unit_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .PTR_W(PTR_W), .COST_W(COST_W),
  .TAKEN_CYC(TAKEN_CYC), .NOT_TAKEN_CYC(NOT_TAKEN_CYC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .add_en(add_en), .sub_en(sub_en),
  .imm(imm), .cmp_en(cmp_en), .mod_en(mod_en), .mod_ind(mod_ind),
  .mod_ptr_ld(mod_ptr_ld), .loop_en(loop_en), .data_addr(data_addr),
  .cur_ptr(cur_ptr), .test_flag(test_flag), .loop_valid(loop_valid),
  .loop_taken(loop_taken), .loop_cost(loop_cost)
);

// File: tb/test_aux_addr_unit.sv
module test_aux_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 0, add_en = 0, sub_en = 0, cmp_en = 0;
  logic        mod_en = 0, mod_ind = 0, mod_ptr_ld = 0, loop_en = 0;
  logic [2:0]  ld_sel = 0, mod_ptr = 0;
  logic [15:0] ld_val = 0;
  logic [7:0]  imm = 0;
  logic [1:0]  cmp_cond = 0, mod_step = 0;
  logic [15:0] data_addr;
  logic [2:0]  cur_ptr, loop_cost;
  logic        test_flag, loop_valid, loop_taken;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] addr;
    logic [2:0]  ptr;
    logic        flag;
    logic        lv;
    logic        lt;
    logic [2:0]  cost;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  logic [15:0] m_bank [8];
  logic [2:0]  m_ptr;
  logic        m_flag;

  always #5 clk = ~clk;

  aux_addr_unit i_aux_addr_unit (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
    .add_en(add_en), .sub_en(sub_en), .imm(imm), .cmp_en(cmp_en),
    .cmp_cond(cmp_cond), .mod_en(mod_en), .mod_ind(mod_ind),
    .mod_step(mod_step), .mod_ptr_ld(mod_ptr_ld), .mod_ptr(mod_ptr),
    .loop_en(loop_en), .data_addr(data_addr), .cur_ptr(cur_ptr),
    .test_flag(test_flag), .loop_valid(loop_valid), .loop_taken(loop_taken),
    .loop_cost(loop_cost)
  );

  // Monitor: compares one expected item per clock edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (data_addr !== e.addr || cur_ptr !== e.ptr || test_flag !== e.flag ||
          loop_valid !== e.lv || loop_taken !== e.lt || loop_cost !== e.cost) begin
        n_fail++;
        $display("FAIL %s: got addr=%h ptr=%0d flag=%b lv=%b lt=%b cost=%0d exp addr=%h ptr=%0d flag=%b lv=%b lt=%b cost=%0d",
                 e.tag, data_addr, cur_ptr, test_flag, loop_valid, loop_taken, loop_cost,
                 e.addr, e.ptr, e.flag, e.lv, e.lt, e.cost);
      end
    end
  end

  task automatic op(input bit ld, input logic [2:0] lsel, input logic [15:0] lval,
                    input bit ad, input bit sb, input logic [7:0] im,
                    input bit cm, input logic [1:0] cc,
                    input bit md, input bit mi, input logic [1:0] st,
                    input bit pl, input logic [2:0] pn, input bit lp, input string tag);
    exp_t e;
    logic [15:0] cur;
    @(negedge clk);
    ld_en = ld; ld_sel = lsel; ld_val = lval; add_en = ad; sub_en = sb; imm = im;
    cmp_en = cm; cmp_cond = cc; mod_en = md; mod_ind = mi; mod_step = st;
    mod_ptr_ld = pl; mod_ptr = pn; loop_en = lp;
    cur = m_bank[m_ptr];
    e.lv = lp;
    e.lt = lp && (cur != 16'h0);
    e.cost = !lp ? 3'd0 : (e.lt ? 3'd4 : 3'd2);
    if (cm) begin
      case (cc)
        2'b00: m_flag = (cur == m_bank[0]);
        2'b01: m_flag = (cur <  m_bank[0]);
        2'b10: m_flag = (cur >  m_bank[0]);
        default: m_flag = (cur != m_bank[0]);
      endcase
    end
    if (ld) m_bank[lsel] = lval;
    else if (ad) m_bank[m_ptr] = cur + {8'h0, im};
    else if (sb) m_bank[m_ptr] = cur - {8'h0, im};
    else if (md && mi && st == 2'b01) m_bank[m_ptr] = cur + 16'd1;
    else if (md && mi && st == 2'b10) m_bank[m_ptr] = cur - 16'd1;
    if (md && mi && pl) m_ptr = pn;
    e.addr = m_bank[m_ptr];
    e.ptr = m_ptr;
    e.flag = m_flag;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic do_load(input logic [2:0] s, input logic [15:0] v, input string tag);
    op(1, s, v, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_add(input logic [7:0] v, input string tag);
    op(0, 0, 0, 1, 0, v, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_sub(input logic [7:0] v, input string tag);
    op(0, 0, 0, 0, 1, v, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_cmp(input logic [1:0] c, input string tag);
    op(0, 0, 0, 0, 0, 0, 1, c, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic do_mod(input bit mi, input logic [1:0] st, input bit pl,
                        input logic [2:0] pn, input bit lp, input string tag);
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, mi, st, pl, pn, lp, tag);
  endtask
  task automatic do_idle(input string tag);
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_bank[i] = 16'h0;
    m_ptr = 3'd0;
    m_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_checks++;
    if (data_addr !== 16'h0 || cur_ptr !== 3'd0 || test_flag !== 1'b0 ||
        loop_valid !== 1'b0 || loop_taken !== 1'b0 || loop_cost !== 3'd0) begin
      n_fail++;
      $display("FAIL R1: got addr=%h ptr=%0d flag=%b lv=%b exp all zero",
               data_addr, cur_ptr, test_flag, loop_valid);
    end
    do_load(3'd0, 16'd100,  "R3 load current reg0");
    do_load(3'd3, 16'h1234, "R3 load non-current reg3");
    do_mod(1, 2'b00, 1, 3'd3, 0, "R8 R2 pointer to reg3");
    do_add(8'hFF, "R4 add no wrap");
    do_load(3'd3, 16'hFFF0, "R3 reload current");
    do_add(8'h20, "R4 add wrap");
    do_sub(8'h11, "R5 sub wrap");
    do_sub(8'h05, "R5 sub plain");
    do_cmp(2'b10, "R6 greater true");
    do_cmp(2'b01, "R6 less false");
    do_cmp(2'b11, "R6 not-equal true");
    do_cmp(2'b00, "R6 equal false");
    do_load(3'd3, 16'd100, "R3 equalise");
    do_cmp(2'b00, "R6 equal true");
    do_idle("R6 flag held");
    do_load(3'd3, 16'd50, "R3 below ref");
    do_cmp(2'b01, "R6 less true");
    do_cmp(2'b10, "R6 greater false");
    do_mod(1, 2'b01, 0, 3'd0, 0, "R7 step inc");
    do_mod(1, 2'b10, 0, 3'd0, 0, "R7 step dec");
    do_mod(1, 2'b11, 0, 3'd0, 0, "R7 step reserved");
    do_mod(1, 2'b01, 1, 3'd5, 0, "R8 inc then move");
    do_mod(1, 2'b00, 1, 3'd3, 0, "R8 old reg incremented");
    do_mod(0, 2'b01, 1, 3'd1, 0, "R9 direct mode ignored");
    do_mod(1, 2'b00, 1, 3'd5, 0, "R8 move to reg5");
    do_mod(1, 2'b00, 0, 3'd0, 1, "R10 zero not taken");
    do_load(3'd5, 16'd2, "R3 loop count");
    do_mod(1, 2'b10, 0, 3'd0, 1, "R11 taken with dec");
    do_mod(1, 2'b10, 0, 3'd0, 1, "R11 taken reaching zero");
    do_mod(1, 2'b10, 0, 3'd0, 1, "R10 not taken and wraps");
    do_idle("R10 idle clears loop");
    op(1, 3'd5, 16'h0AAA, 1, 0, 8'h01, 0, 0, 0, 0, 0, 0, 0, 0, "R12 load beats add");
    op(0, 0, 0, 1, 1, 8'h10, 0, 0, 0, 0, 0, 0, 0, 0, "R12 add beats sub");
    op(0, 0, 0, 0, 1, 8'h02, 0, 0, 1, 1, 2'b01, 0, 0, 0, "R12 sub beats step");
    do_idle("R2 final");
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule